// File: doc/BRIEF.md
# Region Access Permission Checker

This block sits beside a bus fabric and judges each access while it is in flight. An access presents an address, the number of the initiating master, a kind (read, write or instruction fetch), a privilege mode and a process tag. A bank of region descriptors is supplied as static inputs. Each descriptor gives an address window, an enable, per-master rights, a process tag and a tag mask. The block finds every enabled descriptor whose window covers the address and evaluates the rights for that master and mode. It returns a grant in the same cycle. Programming the descriptors, the bus protocol and any interrupt wiring are left to the surrounding logic.

Masters below `N_RWX_MST` carry a rich rights field with separate user and privileged encodings, plus optional process-tag matching. The masters above that get a plain read-enable and write-enable pair. A denied access is classified and recorded in a per-target-port error slot. The slot keeps the details of the first fault until it is acknowledged.

Top module: `mpc_top`

## Requirements
- R1: A region covers an address when `addr[ADDR_W-1:5]` lies between the start's and end's upper bits. The bounds are inclusive, the start's low 5 bits count as 0 and the end's low 5 bits count as 1.
- R2: With `glb_en` low, every valid access is granted and no error slot is written.
- R3: A region whose `rgn_valid` bit is low never covers any address.
- R4: For a master m below 4, the 6-bit field at `rgn_rights[m*6 +: 6]` holds user rights in bits [2:0]. Bit 2 allows read, bit 1 allows write and bit 0 allows fetch. Kind is encoded 0 read, 1 write, 2 fetch.
- R5: The privileged rights for such a master are in field bits [4:3]: 0 gives read/write/fetch, 1 gives read/fetch, 2 gives read/write, and 3 applies the user bits. They are used when `acc_super` is 1.
- R6: For a master m of 4 or more, bits `rgn_rights[24+(m-4)*2 +: 2]` are {write, read}. A fetch is judged as a read, and `acc_super` has no effect.
- R7: When field bit 5 of a master below 4 is set, the region covers an access only if `(acc_pid ^ rgn_pid) & ~rgn_pid_mask` is zero.
- R8: When several regions cover the address, the access is granted if any one of them allows it.
- R9: The fault class of a denied access is 0 when no region covers it, 1 when exactly one region covers it and 2 when two or more regions cover it.
- R10: A recorded fault holds the master, the address, a write flag (1 only for kind write) and an attribute `{acc_super, kind!=fetch}`. The attribute reads 0 user fetch, 1 user data, 2 privileged fetch and 3 privileged data.
- R11: A fault on port p sets `err_flag[p]` on the next edge. The details then stay frozen until `err_clr[p]` is pulsed. A fault in the clear cycle is recorded and leaves the flag set.
- R12: With `acc_valid` low, `acc_grant` is 0 and nothing is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global checking enable |
| rgn_valid | input | N_REG | Per-region enable |
| rgn_start | input | N_REG*ADDR_W | Region start addresses |
| rgn_end | input | N_REG*ADDR_W | Region end addresses |
| rgn_rights | input | N_REG*RGT_W | Per-region master rights words |
| rgn_pid | input | N_REG*PID_W | Region process tags |
| rgn_pid_mask | input | N_REG*PID_W | Tag bits ignored in the comparison |
| acc_valid | input | 1 | Access present |
| acc_port | input | PORT_W | Target port of the access |
| acc_addr | input | ADDR_W | Access address |
| acc_master | input | MST_W | Initiating master |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_super | input | 1 | Privileged mode |
| acc_pid | input | PID_W | Access process tag |
| acc_grant | output | 1 | Access allowed (combinational) |
| err_clr | input | N_PORT | Write-one acknowledge per port |
| err_flag | output | N_PORT | Fault recorded per port |
| err_class | output | N_PORT*2 | Fault class per port |
| err_master | output | N_PORT*MST_W | Faulting master per port |
| err_addr | output | N_PORT*ADDR_W | Faulting address per port |
| err_write | output | N_PORT | Fault was a write |
| err_attr | output | N_PORT*2 | Mode/kind attribute |

## Verification
The properties assume that the descriptors stay static while accesses flow and that `acc_kind` never takes the unused code 3. They also assume that `acc_port` stays below `N_PORT`. The stimulus writes every descriptor during reset and changes only `rgn_valid` and `glb_en`, always between accesses. It uses only the three defined kinds and the two existing ports. Acknowledge pulses last exactly one cycle, so the hold and clear properties see each pulse as one event.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_FETCH = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      CLS_NOHIT  = 2'd0,
      CLS_SINGLE = 2'd1,
      CLS_MULTI  = 2'd2
   } err_cls_e;

   localparam int RICH_FLD_W  = 6;  // user[2:0], priv[4:3], tag enable[5]
   localparam int PLAIN_FLD_W = 2;  // read[0], write[1]
endpackage

// File: rtl/mpc_rights_eval.sv
module mpc_rights_eval
   import mpc_pkg::*;
#(
   parameter int N_RWX_MST = 4,
   parameter int N_RW_MST  = 4,
   parameter int MST_W     = 3,
   localparam int RGT_W    = N_RWX_MST*RICH_FLD_W + N_RW_MST*PLAIN_FLD_W
) (
   input  logic [RGT_W-1:0] rights,
   input  logic [MST_W-1:0] master,
   input  logic [1:0]       kind,
   input  logic             super_md,
   output logic             allow,
   output logic             tag_req
);
   localparam int PLAIN_BASE = N_RWX_MST*RICH_FLD_W;

   logic [RICH_FLD_W-1:0]  rich_f;
   logic [PLAIN_FLD_W-1:0] plain_f;
   logic [2:0]             eff;
   int                     m_i;

   always_comb begin
      m_i     = int'(master);
      rich_f  = '0;
      plain_f = '0;
      eff     = '0;
      allow   = 1'b0;
      tag_req = 1'b0;
      if (m_i < N_RWX_MST) begin
         rich_f  = rights[m_i*RICH_FLD_W +: RICH_FLD_W];
         tag_req = rich_f[5];
         if (super_md) begin
            unique case (rich_f[4:3])
               2'd0:    eff = 3'b111;
               2'd1:    eff = 3'b101;
               2'd2:    eff = 3'b110;
               default: eff = rich_f[2:0];
            endcase
         end else begin
            eff = rich_f[2:0];
         end
         unique case (kind)
            KIND_READ:  allow = eff[2];
            KIND_WRITE: allow = eff[1];
            KIND_FETCH: allow = eff[0];
            default:    allow = 1'b0;
         endcase
      end else if (m_i < N_RWX_MST + N_RW_MST) begin
         plain_f = rights[PLAIN_BASE + (m_i - N_RWX_MST)*PLAIN_FLD_W +: PLAIN_FLD_W];
         unique case (kind)
            KIND_READ, KIND_FETCH: allow = plain_f[0];
            KIND_WRITE:            allow = plain_f[1];
            default:               allow = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/mpc_region_match.sv
module mpc_region_match
   import mpc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_W    = 5,
   parameter int PID_W     = 8,
   parameter int N_RWX_MST = 4,
   parameter int N_RW_MST  = 4,
   parameter int MST_W     = 3,
   localparam int RGT_W    = N_RWX_MST*RICH_FLD_W + N_RW_MST*PLAIN_FLD_W
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   input  logic [RGT_W-1:0]  rights,
   input  logic [PID_W-1:0]  tag,
   input  logic [PID_W-1:0]  tag_mask,
   input  logic [ADDR_W-1:0] addr,
   input  logic [MST_W-1:0]  master,
   input  logic [1:0]        kind,
   input  logic              super_md,
   input  logic [PID_W-1:0]  acc_tag,
   output logic              hit,
   output logic              allow
);
   logic in_win;
   logic tag_ok;
   logic tag_req;
   logic r_allow;

   // Only the upper bits take part: the granule bits are implied.
   assign in_win = (addr[ADDR_W-1:GRAN_W] >= lo[ADDR_W-1:GRAN_W]) &&
                   (addr[ADDR_W-1:GRAN_W] <= hi[ADDR_W-1:GRAN_W]);

   mpc_rights_eval #(
      .N_RWX_MST(N_RWX_MST),
      .N_RW_MST (N_RW_MST),
      .MST_W    (MST_W)
   ) eval_i (
      .rights  (rights),
      .master  (master),
      .kind    (kind),
      .super_md(super_md),
      .allow   (r_allow),
      .tag_req (tag_req)
   );

   assign tag_ok = !tag_req || (((acc_tag ^ tag) & ~tag_mask) == '0);
   assign hit    = valid && in_win && tag_ok;
   assign allow  = hit && r_allow;
endmodule

// File: rtl/mpc_err_slot.sv
module mpc_err_slot #(
   parameter int ADDR_W = 32,
   parameter int MST_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault,
   input  logic              clr,
   input  logic [1:0]        f_class,
   input  logic [MST_W-1:0]  f_master,
   input  logic [ADDR_W-1:0] f_addr,
   input  logic              f_write,
   input  logic [1:0]        f_attr,
   output logic              flag,
   output logic [1:0]        s_class,
   output logic [MST_W-1:0]  s_master,
   output logic [ADDR_W-1:0] s_addr,
   output logic              s_write,
   output logic [1:0]        s_attr
);
   logic take;

   assign take = fault && (!flag || clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag     <= 1'b0;
         s_class  <= '0;
         s_master <= '0;
         s_addr   <= '0;
         s_write  <= 1'b0;
         s_attr   <= '0;
      end else begin
         if (take) begin
            flag     <= 1'b1;
            s_class  <= f_class;
            s_master <= f_master;
            s_addr   <= f_addr;
            s_write  <= f_write;
            s_attr   <= f_attr;
         end else if (clr) begin
            flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mpc_top.sv
module mpc_top
   import mpc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_W    = 5,
   parameter int N_REG     = 4,
   parameter int N_RWX_MST = 4,
   parameter int N_RW_MST  = 4,
   parameter int PID_W     = 8,
   parameter int N_PORT    = 2,
   localparam int N_MST    = N_RWX_MST + N_RW_MST,
   localparam int MST_W    = (N_MST > 1) ? $clog2(N_MST) : 1,
   localparam int PORT_W   = (N_PORT > 1) ? $clog2(N_PORT) : 1,
   localparam int RGT_W    = N_RWX_MST*RICH_FLD_W + N_RW_MST*PLAIN_FLD_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     glb_en,
   input  logic [N_REG-1:0]         rgn_valid,
   input  logic [N_REG*ADDR_W-1:0]  rgn_start,
   input  logic [N_REG*ADDR_W-1:0]  rgn_end,
   input  logic [N_REG*RGT_W-1:0]   rgn_rights,
   input  logic [N_REG*PID_W-1:0]   rgn_pid,
   input  logic [N_REG*PID_W-1:0]   rgn_pid_mask,
   input  logic                     acc_valid,
   input  logic [PORT_W-1:0]        acc_port,
   input  logic [ADDR_W-1:0]        acc_addr,
   input  logic [MST_W-1:0]         acc_master,
   input  logic [1:0]               acc_kind,
   input  logic                     acc_super,
   input  logic [PID_W-1:0]         acc_pid,
   output logic                     acc_grant,
   input  logic [N_PORT-1:0]        err_clr,
   output logic [N_PORT-1:0]        err_flag,
   output logic [N_PORT*2-1:0]      err_class,
   output logic [N_PORT*MST_W-1:0]  err_master,
   output logic [N_PORT*ADDR_W-1:0] err_addr,
   output logic [N_PORT-1:0]        err_write,
   output logic [N_PORT*2-1:0]      err_attr
);
   // Elaboration checks on the parameter set
   if (GRAN_W < 1 || GRAN_W >= ADDR_W) begin : g_bad_gran
      $error("GRAN_W must lie between 1 and ADDR_W-1");
   end
   if (N_REG < 1) begin : g_bad_reg
      $error("N_REG must be at least 1");
   end
   if (N_PORT < 1) begin : g_bad_port
      $error("N_PORT must be at least 1");
   end
   if (N_RWX_MST < 1) begin : g_bad_mst
      $error("N_RWX_MST must be at least 1");
   end

   logic [N_REG-1:0] hits;
   logic [N_REG-1:0] allows;
   logic             any_hit;
   logic             multi_hit;
   logic             any_allow;
   logic             deny;
   logic [1:0]       f_class;
   logic             f_write;
   logic [1:0]       f_attr;

   for (genvar r = 0; r < N_REG; r++) begin : g_rgn
      mpc_region_match #(
         .ADDR_W   (ADDR_W),
         .GRAN_W   (GRAN_W),
         .PID_W    (PID_W),
         .N_RWX_MST(N_RWX_MST),
         .N_RW_MST (N_RW_MST),
         .MST_W    (MST_W)
      ) match_i (
         .valid   (rgn_valid[r]),
         .lo      (rgn_start[r*ADDR_W +: ADDR_W]),
         .hi      (rgn_end[r*ADDR_W +: ADDR_W]),
         .rights  (rgn_rights[r*RGT_W +: RGT_W]),
         .tag     (rgn_pid[r*PID_W +: PID_W]),
         .tag_mask(rgn_pid_mask[r*PID_W +: PID_W]),
         .addr    (acc_addr),
         .master  (acc_master),
         .kind    (acc_kind),
         .super_md(acc_super),
         .acc_tag (acc_pid),
         .hit     (hits[r]),
         .allow   (allows[r])
      );
   end

   assign any_hit   = |hits;
   assign multi_hit = |(hits & (hits - N_REG'(1)));
   assign any_allow = |allows;

   assign acc_grant = acc_valid && (!glb_en || any_allow);
   assign deny      = acc_valid && glb_en && !any_allow;

   always_comb begin
      if (!any_hit)       f_class = CLS_NOHIT;
      else if (multi_hit) f_class = CLS_MULTI;
      else                f_class = CLS_SINGLE;
   end

   assign f_write = (acc_kind == KIND_WRITE);
   assign f_attr  = {acc_super, acc_kind != KIND_FETCH};

   for (genvar p = 0; p < N_PORT; p++) begin : g_port
      mpc_err_slot #(
         .ADDR_W(ADDR_W),
         .MST_W (MST_W)
      ) slot_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .fault   (deny && (acc_port == PORT_W'(p))),
         .clr     (err_clr[p]),
         .f_class (f_class),
         .f_master(acc_master),
         .f_addr  (acc_addr),
         .f_write (f_write),
         .f_attr  (f_attr),
         .flag    (err_flag[p]),
         .s_class (err_class[p*2 +: 2]),
         .s_master(err_master[p*MST_W +: MST_W]),
         .s_addr  (err_addr[p*ADDR_W +: ADDR_W]),
         .s_write (err_write[p]),
         .s_attr  (err_attr[p*2 +: 2])
      );
   end
endmodule

// File: rtl/mpc_top_chk.sv
module mpc_top_chk #(
   parameter int ADDR_W = 32,
   parameter int MST_W  = 3,
   parameter int N_PORT = 2,
   parameter int PORT_W = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     glb_en,
   input logic                     acc_valid,
   input logic [PORT_W-1:0]        acc_port,
   input logic                     acc_grant,
   input logic [N_PORT-1:0]        err_clr,
   input logic [N_PORT-1:0]        err_flag,
   input logic [N_PORT*2-1:0]      err_class,
   input logic [N_PORT*ADDR_W-1:0] err_addr,
   input logic [N_PORT*MST_W-1:0]  err_master
);
   p_off_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !glb_en) |-> acc_grant);

   p_idle_nogrant_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !acc_grant);

   for (genvar p = 0; p < N_PORT; p++) begin : g_p
      logic fault_here;
      assign fault_here = acc_valid && !acc_grant && (acc_port == PORT_W'(p));

      p_flag_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_here && !err_flag[p]) |=> err_flag[p]);

      p_details_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (err_flag[p] && !err_clr[p]) |=>
            (err_flag[p] && $stable(err_addr[p*ADDR_W +: ADDR_W]) &&
             $stable(err_master[p*MST_W +: MST_W])));

      p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (err_clr[p] && !fault_here) |=> !err_flag[p]);

      p_class_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
         err_flag[p] |-> (err_class[p*2 +: 2] != 2'd3));

      p_off_nocapture_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!glb_en && !err_flag[p]) |=> !err_flag[p]);
   end
endmodule

bind mpc_top mpc_top_chk #(
   .ADDR_W(ADDR_W),
   .MST_W (MST_W),
   .N_PORT(N_PORT),
   .PORT_W(PORT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .glb_en    (glb_en),
   .acc_valid (acc_valid),
   .acc_port  (acc_port),
   .acc_grant (acc_grant),
   .err_clr   (err_clr),
   .err_flag  (err_flag),
   .err_class (err_class),
   .err_addr  (err_addr),
   .err_master(err_master)
);

// File: tb/mpc_top_tb_top.sv
module mpc_top_tb_top;
   localparam int AW = 32;
   localparam int NR = 4;
   localparam int RW = 32;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          glb_en;
   logic [NR-1:0] rgn_valid;
   logic [NR*AW-1:0] rgn_start, rgn_end;
   logic [NR*RW-1:0] rgn_rights;
   logic [NR*PW-1:0] rgn_pid, rgn_pid_mask;
   logic          acc_valid;
   logic [0:0]    acc_port;
   logic [AW-1:0] acc_addr;
   logic [2:0]    acc_master;
   logic [1:0]    acc_kind;
   logic          acc_super;
   logic [PW-1:0] acc_pid;
   logic          acc_grant;
   logic [1:0]    err_clr;
   logic [1:0]    err_flag;
   logic [3:0]    err_class;
   logic [5:0]    err_master;
   logic [2*AW-1:0] err_addr;
   logic [1:0]    err_write;
   logic [3:0]    err_attr;

   int checks = 0;
   int errors = 0;
   bit   q_g[$];
   string q_t[$];

   always #10 clk = ~clk;

   mpc_top dut_i (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rgn_valid(rgn_valid),
      .rgn_start(rgn_start), .rgn_end(rgn_end), .rgn_rights(rgn_rights),
      .rgn_pid(rgn_pid), .rgn_pid_mask(rgn_pid_mask), .acc_valid(acc_valid),
      .acc_port(acc_port), .acc_addr(acc_addr), .acc_master(acc_master),
      .acc_kind(acc_kind), .acc_super(acc_super), .acc_pid(acc_pid),
      .acc_grant(acc_grant), .err_clr(err_clr), .err_flag(err_flag),
      .err_class(err_class), .err_master(err_master), .err_addr(err_addr),
      .err_write(err_write), .err_attr(err_attr)
   );

   // Monitor: compares the grant half a cycle after each driven access
   always @(negedge clk) begin
      if (q_g.size() > 0) begin
         bit    eg;
         string tg;
         eg = q_g.pop_front();
         tg = q_t.pop_front();
         checks++;
         if (acc_grant !== eg) begin
            errors++;
            $display("FAIL %s grant actual=%0b expected=%0b", tg, acc_grant, eg);
         end
      end
   end

   task automatic drv(input logic v, input int port, input logic [31:0] addr,
                      input int m, input logic [1:0] kind, input logic sup,
                      input logic [7:0] pid, input logic [1:0] clr,
                      input bit eg, input string tag);
      @(posedge clk); #2;
      acc_valid  = v;
      acc_port   = 1'(port);
      acc_addr   = addr;
      acc_master = 3'(m);
      acc_kind   = kind;
      acc_super  = sup;
      acc_pid    = pid;
      err_clr    = clr;
      q_g.push_back(eg);
      q_t.push_back(tag);
   endtask

   task automatic idle();
      @(posedge clk); #2;
      acc_valid = 1'b0;
      err_clr   = 2'b00;
   endtask

   task automatic chk_slot(input int p, input bit fl, input logic [1:0] cl,
                           input int m, input logic [31:0] a, input bit w,
                           input logic [1:0] at, input string tag);
      logic [1:0]  g_cl;
      logic [2:0]  g_m;
      logic [31:0] g_a;
      g_cl = err_class[p*2 +: 2];
      g_m  = err_master[p*3 +: 3];
      g_a  = err_addr[p*AW +: AW];
      checks++;
      if (err_flag[p] !== fl || g_cl !== cl || g_m !== 3'(m) || g_a !== a ||
          err_write[p] !== w || err_attr[p*2 +: 2] !== at) begin
         errors++;
         $display("FAIL %s port%0d actual flag=%0b cls=%0d m=%0d a=%h w=%0b at=%0d expected flag=%0b cls=%0d m=%0d a=%h w=%0b at=%0d",
                  tag, p, err_flag[p], g_cl, g_m, g_a, err_write[p], err_attr[p*2 +: 2],
                  fl, cl, m, a, w, at);
      end
   endtask

   task automatic chk_flag(input int p, input bit fl, input string tag);
      checks++;
      if (err_flag[p] !== fl) begin
         errors++;
         $display("FAIL %s port%0d flag actual=%0b expected=%0b", tag, p, err_flag[p], fl);
      end
   endtask

   task automatic clear_port(input int p);
      @(posedge clk); #2;
      acc_valid = 1'b0;
      err_clr   = 2'(1 << p);
      @(posedge clk); #2;
      err_clr   = 2'b00;
      chk_flag(p, 1'b0, "R11 clear");
   endtask

   initial begin
      glb_en = 1'b1; rgn_valid = 4'b1101;
      rgn_start = '0; rgn_end = '0; rgn_rights = '0; rgn_pid = '0; rgn_pid_mask = '0;
      acc_valid = 0; acc_port = 0; acc_addr = 0; acc_master = 0; acc_kind = 0;
      acc_super = 0; acc_pid = 0; err_clr = 0;
      // Region 0: low bits of the bounds given off-granule on purpose
      rgn_start[0*AW +: AW] = 32'h101F; rgn_end[0*AW +: AW] = 32'h1FE0;
      rgn_rights[0*RW + 0  +: 6] = {1'b0, 2'd3, 3'd7};
      rgn_rights[0*RW + 6  +: 6] = {1'b0, 2'd0, 3'd4};
      rgn_rights[0*RW + 12 +: 6] = {1'b0, 2'd1, 3'd0};
      rgn_rights[0*RW + 24 +: 8] = {2'b11, 2'b00, 2'b10, 2'b01};
      // Region 1: starts disabled
      rgn_start[1*AW +: AW] = 32'h2000; rgn_end[1*AW +: AW] = 32'h2FE0;
      rgn_rights[1*RW + 0 +: 6] = {1'b0, 2'd0, 3'd7};
      // Region 2: overlaps the top of region 0
      rgn_start[2*AW +: AW] = 32'h1800; rgn_end[2*AW +: AW] = 32'h1FE0;
      rgn_rights[2*RW + 6 +: 6] = {1'b0, 2'd0, 3'd6};
      // Region 3: tag-checked window for master 3
      rgn_start[3*AW +: AW] = 32'h8000; rgn_end[3*AW +: AW] = 32'h80E0;
      rgn_rights[3*RW + 18 +: 6] = {1'b1, 2'd3, 3'd2};
      rgn_pid[3*PW +: PW] = 8'h5A; rgn_pid_mask[3*PW +: PW] = 8'h0F;

      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk_flag(0, 1'b0, "R12 reset"); chk_flag(1, 1'b0, "R12 reset");
      checks++;
      if (acc_grant !== 1'b0) begin
         errors++; $display("FAIL R12 reset grant actual=%0b expected=0", acc_grant);
      end

      // R1 / R9 / R10: below window, first fault on port 0
      drv(1, 0, 32'h0FFF, 0, 0, 0, 0, 0, 0, "R1 below start");
      idle();
      chk_slot(0, 1, 0, 0, 32'h0FFF, 0, 1, "R10 no-hit capture");
      drv(1, 0, 32'h1000, 0, 0, 0, 0, 0, 1, "R1 start granule");
      drv(1, 0, 32'h1FFF, 0, 0, 0, 0, 0, 1, "R1 end granule");
      drv(1, 0, 32'h2000, 0, 0, 0, 0, 0, 0, "R3 disabled region");
      idle();
      chk_slot(0, 1, 0, 0, 32'h0FFF, 0, 1, "R11 hold on second fault");
      @(posedge clk); #2 rgn_valid[1] = 1'b1;
      drv(1, 0, 32'h2000, 0, 0, 0, 0, 0, 1, "R3 enabled region");

      // R4 user rights
      drv(1, 0, 32'h1100, 1, 0, 0, 0, 0, 1, "R4 user read");
      drv(1, 0, 32'h1100, 1, 1, 0, 0, 0, 0, "R4 user write denied");
      drv(1, 0, 32'h1100, 1, 2, 0, 0, 0, 0, "R4 user fetch denied");
      drv(1, 0, 32'h1100, 0, 2, 0, 0, 0, 1, "R4 user fetch allowed");
      // R5 privileged rights
      drv(1, 0, 32'h1100, 1, 1, 1, 0, 0, 1, "R5 priv code0 write");
      drv(1, 0, 32'h1100, 2, 1, 1, 0, 0, 0, "R5 priv code1 write");
      drv(1, 0, 32'h1100, 2, 2, 1, 0, 0, 1, "R5 priv code1 fetch");
      drv(1, 0, 32'h1100, 2, 0, 0, 0, 0, 0, "R5 user side of m2");
      drv(1, 0, 32'h1100, 0, 1, 1, 0, 0, 1, "R5 priv code3 uses user");
      // R6 plain masters
      drv(1, 0, 32'h1100, 4, 0, 0, 0, 0, 1, "R6 m4 read");
      drv(1, 0, 32'h1100, 4, 1, 0, 0, 0, 0, "R6 m4 write");
      drv(1, 0, 32'h1100, 4, 2, 0, 0, 0, 1, "R6 m4 fetch as read");
      drv(1, 0, 32'h1100, 4, 1, 1, 0, 0, 0, "R6 m4 priv write");
      drv(1, 0, 32'h1100, 5, 1, 0, 0, 0, 1, "R6 m5 write");
      drv(1, 0, 32'h1100, 5, 0, 1, 0, 0, 0, "R6 m5 read");
      drv(1, 0, 32'h1100, 6, 0, 0, 0, 0, 0, "R6 m6 none");
      drv(1, 0, 32'h1100, 7, 1, 0, 0, 0, 1, "R6 m7 write");
      // R8 overlap, any region allows
      drv(1, 0, 32'h1900, 1, 1, 0, 0, 0, 1, "R8 overlap grant");

      // R9 overlapping fault on port 1
      drv(1, 1, 32'h1900, 2, 0, 0, 0, 0, 0, "R9 overlap deny");
      idle();
      chk_slot(1, 1, 2, 2, 32'h1900, 0, 1, "R9 class multi");
      clear_port(1);
      drv(1, 1, 32'h1100, 1, 1, 0, 0, 0, 0, "R9 single deny");
      idle();
      chk_slot(1, 1, 1, 1, 32'h1100, 1, 1, "R9 class single");
      clear_port(1);
      // R7 process tag
      drv(1, 1, 32'h8010, 3, 1, 0, 8'h53, 0, 1, "R7 tag masked match");
      drv(1, 1, 32'h8010, 3, 1, 0, 8'h6A, 0, 0, "R7 tag mismatch");
      idle();
      chk_slot(1, 1, 0, 3, 32'h8010, 1, 1, "R7 mismatch is no-hit");
      clear_port(1);
      drv(1, 1, 32'h8020, 3, 2, 1, 8'h5A, 0, 0, "R10 priv fetch deny");
      idle();
      chk_slot(1, 1, 1, 3, 32'h8020, 0, 2, "R10 priv fetch attr");
      // R11 fault in the clear cycle is recorded
      drv(1, 1, 32'h1100, 6, 1, 1, 0, 2'b10, 0, "R11 fault with clear");
      idle();
      chk_slot(1, 1, 1, 6, 32'h1100, 1, 3, "R11 clear plus fault");
      clear_port(1);

      // R2 checking off
      @(posedge clk); #2 glb_en = 1'b0;
      drv(1, 1, 32'h0FFF, 6, 0, 0, 0, 0, 1, "R2 off grants");
      idle();
      chk_flag(1, 1'b0, "R2 off no capture");
      @(posedge clk); #2 glb_en = 1'b1;
      // R12 no access present
      drv(0, 1, 32'h0FFF, 6, 0, 0, 0, 0, 0, "R12 idle no grant");
      idle();
      chk_flag(1, 1'b0, "R12 idle no capture");
      chk_slot(0, 1, 0, 0, 32'h0FFF, 0, 1, "R11 port 0 untouched");

      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule